// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block collects six interrupt sources from surrounding logic into one active-low request pin. Each source owns a sticky status bit. A per-source latch enable decides whether the bit may capture activity at all. A separate per-source mask decides whether a captured bit may drive the request. The source inputs may be single-cycle pulses or held levels, and both are treated the same way: the input is sampled on every rising clock edge.

Software reaches the block over a plain 16-bit register bus with a combinational read path. The bus holds a control register and a read-only status register. Two control bits shape the request pin. A global mask bit gates every source at once. A mode bit selects between a level request and a fixed-length low pulse. A pending bit has no write-one-to-clear path. Software acknowledges it by writing its latch enable to 0 and then back to 1.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0000 and `irq_n` is high.
- R2: The control register sits at address 0x1010. Bit 15 is the global mask, bit 14 selects pulse mode (1) or level mode (0), bits 13:8 are the latch enables for sources 0..5, and bits 5:0 are the masks for sources 0..5. Bits 7:6 read 0 and ignore writes.
- R3: The status register sits at address 0x1012 and is read-only. Bit i holds the latched status of `src_in[i]`, bits 15:6 read 0, and a write to it changes nothing.
- R4: While the latch enable of source i is 0, status bit i is held at 0, and activity on `src_in[i]` is discarded.
- R5: While the latch enable of source i is 1, a high `src_in[i]` at a rising edge sets status bit i from that edge on. The bit stays set after the input falls.
- R6: Writing latch enable i to 0 clears status bit i. Writing it back to 1 re-arms the source with the bit still clear.
- R7: A source event in the same cycle as a write that sets its latch enable to 0 is discarded, and the status bit stays 0.
- R8: A set status bit whose mask bit is 0 has no effect on `irq_n`.
- R9: While the global mask is 0, `irq_n` is high.
- R10: In level mode with the global mask at 1, `irq_n` is low from the edge at which a set, masked-in status bit appears. It stays low for as long as any such bit remains set.
- R11: In pulse mode with the global mask at 1, a status bit that newly becomes set and masked-in drives `irq_n` low for exactly 4 cycles, starting at that edge. A bit that is already set produces no further pulse when its source fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the strobe (0 when idle) |
| src_in | input | 6 | Source activity, bit i is source i |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A single-cycle pulse on one source is driven under each combination of latch enable, mask, global mask and mode. The status read-back then shows whether the latch, the mask or the output gate decided the result. A second pulse on a source that is already set separates "new bit" detection in pulse mode from plain level following. The acknowledge sequence is tried twice: once as two ordinary writes, and once with the source firing in the same cycle as the disabling write. This shows whether a racing event can slip past the clear. Writes of all ones to both addresses expose the reserved bits and the read-only status register.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NSRC      = 6;
    localparam int DW        = 16;
    localparam int AW        = 16;
    localparam int EN_LSB    = 8;
    localparam int MASK_LSB  = 0;
    localparam int GMASK_BIT = 15;
    localparam int MODE_BIT  = 14;

    typedef struct packed {
        logic            gmask;
        logic            pulse_mode;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] mask;
    } ctl_t;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
#(
    parameter logic [AW-1:0] ADDR_CTL = 16'h1010,
    parameter logic [AW-1:0] ADDR_STS = 16'h1012
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NSRC-1:0] status_q,
    output ctl_t            ctl_d,
    output ctl_t            ctl_q,
    output logic [DW-1:0]   bus_rdata
);
    logic wr_ctl;

    always_comb begin
        ctl_d  = ctl_q;
        wr_ctl = bus_en && bus_we && (bus_addr == ADDR_CTL);
        if (wr_ctl) begin
            ctl_d.gmask      = bus_wdata[GMASK_BIT];
            ctl_d.pulse_mode = bus_wdata[MODE_BIT];
            ctl_d.en         = bus_wdata[EN_LSB +: NSRC];
            ctl_d.mask       = bus_wdata[MASK_LSB +: NSRC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == ADDR_CTL) begin
                bus_rdata[GMASK_BIT]            = ctl_q.gmask;
                bus_rdata[MODE_BIT]             = ctl_q.pulse_mode;
                bus_rdata[EN_LSB +: NSRC]       = ctl_q.en;
                bus_rdata[MASK_LSB +: NSRC]     = ctl_q.mask;
            end else if (bus_addr == ADDR_STS) begin
                bus_rdata[NSRC-1:0]             = status_q;
            end
        end
    end
endmodule

// File: rtl/irq_ctl_latch.sv
module irq_ctl_latch
    import irq_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] en_d,
    output logic [NSRC-1:0] status_d,
    output logic [NSRC-1:0] status_q
);
    // The enable value after this cycle's write gates the capture, so a
    // disabling write wins over a same-cycle event.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_comb status_d[i] = en_d[i] & (status_q[i] | src_in[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_q[i] <= 1'b0;
            else        status_q[i] <= status_d[i];
        end
    end
endmodule

// File: rtl/irq_ctl_out.sv
module irq_ctl_out
    import irq_ctl_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] status_d,
    input  logic [NSRC-1:0] status_q,
    input  logic [NSRC-1:0] mask_d,
    input  logic [NSRC-1:0] mask_q,
    input  logic            gmask_d,
    input  logic            gmask_q,
    input  logic            mode_d,
    input  logic            mode_q,
    output logic            irq_n
);
    localparam int CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [NSRC-1:0] armed;
    } ost_t;

    ost_t st_d, st_q;
    logic [NSRC-1:0] fresh;

    always_comb begin
        st_d.armed = status_d & mask_d;
        fresh      = st_d.armed & ~st_q.armed;
        st_d.cnt   = st_q.cnt;
        if (!gmask_d || !mode_d)  st_d.cnt = '0;
        else if (|fresh)          st_d.cnt = CW'(PULSE_LEN);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (mode_q) irq_n = (st_q.cnt == '0);
        else        irq_n = !(gmask_q && |(status_q & mask_q));
    end
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter logic [15:0] ADDR_CTL  = 16'h1010,
    parameter logic [15:0] ADDR_STS  = 16'h1012,
    parameter int          PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [5:0]  src_in,
    output logic        irq_n
);
    ctl_t            ctl_d, ctl_q;
    logic [NSRC-1:0] status_d, status_q;

    irq_ctl_regs #(.ADDR_CTL(ADDR_CTL), .ADDR_STS(ADDR_STS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_q(status_q),
        .ctl_d(ctl_d), .ctl_q(ctl_q), .bus_rdata(bus_rdata)
    );

    irq_ctl_latch u_latch (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_d(ctl_d.en),
        .status_d(status_d), .status_q(status_q)
    );

    irq_ctl_out #(.PULSE_LEN(PULSE_LEN)) u_out (
        .clk(clk), .rst_n(rst_n), .status_d(status_d), .status_q(status_q),
        .mask_d(ctl_d.mask), .mask_q(ctl_q.mask),
        .gmask_d(ctl_d.gmask), .gmask_q(ctl_q.gmask),
        .mode_d(ctl_d.pulse_mode), .mode_q(ctl_q.pulse_mode),
        .irq_n(irq_n)
    );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
    import irq_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        irq_n,
    input ctl_t        ctl_q,
    input logic [5:0]  status_q
);
    // R4: a disabled source never shows a set status bit
    a_r4_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~ctl_q.en) == '0);

    // R5: a set bit stays set while its enable remains 1
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> (($past(status_q) & ctl_q.en & ~status_q) == '0));

    // R7: a disabling write leaves the affected bits clear
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 16'h1010)
        |=> ((status_q & ~$past(bus_wdata[13:8])) == '0));

    // R9: global mask low keeps the request high
    a_r9_gmask: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.gmask |-> irq_n);

    // R10: level mode follows the masked status
    a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.pulse_mode && ctl_q.gmask && |(status_q & ctl_q.mask)) |-> !irq_n);

    // R11: a pulse lasts more than one cycle
    a_r11_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pulse_mode && $fell(irq_n)) |=> !irq_n);

    // R2: reserved control bits read 0
    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == 16'h1010) |-> bus_rdata[7:6] == 2'b00);
endmodule

bind irq_ctl_top irq_ctl_chk u_chk (.*);

// File: tb/sim_irq_ctl_top.sv
module sim_irq_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  src_in = '0;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] A_CTL = 16'h1010;
    localparam logic [15:0] A_STS = 16'h1012;

    always #2 clk = ~clk;

    irq_ctl_top u0 (.*);

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk); src_in = m;
        @(negedge clk); src_in = '0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(A_CTL, v); check(v, 16'h0000, "R1 control");
        rd(A_STS, v); check(v, 16'h0000, "R1 status");
        check({15'd0, irq_n}, 16'h0001, "R1 irq_n");
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(A_CTL, 16'hFFFF);
        rd(A_CTL, v); check(v, 16'hFF3F, "R2 reserved bits");
        wr(A_CTL, 16'h0000);
        rd(A_CTL, v); check(v, 16'h0000, "R2 clear");
        wr(A_CTL, 16'h2000);             // enable source 5 only
        pulse(6'h20);
        wr(A_STS, 16'hFFFF);
        rd(A_STS, v); check(v, 16'h0020, "R3 status read-only");
        wr(A_CTL, 16'h0000);
    endtask

    task automatic t_disabled;
        logic [15:0] v;
        wr(A_CTL, 16'h8000 | 16'h003F);  // masks on, enables off
        pulse(6'h3F);
        rd(A_STS, v); check(v, 16'h0000, "R4 disabled ignores");
        check({15'd0, irq_n}, 16'h0001, "R4 irq_n high");
    endtask

    task automatic t_latch_mask;
        logic [15:0] v;
        wr(A_CTL, 16'hBF00);             // gmask, all enabled, none masked
        pulse(6'h04);
        rd(A_STS, v); check(v, 16'h0004, "R5 latch source 2");
        check({15'd0, irq_n}, 16'h0001, "R8 unmasked no irq");
        repeat (3) @(negedge clk);
        rd(A_STS, v); check(v, 16'h0004, "R5 sticky");
        wr(A_CTL, 16'hBF04);
        check({15'd0, irq_n}, 16'h0000, "R10 level low");
        pulse(6'h01);
        wr(A_CTL, 16'hBF05);
        wr(A_CTL, 16'h3F05);
        check({15'd0, irq_n}, 16'h0001, "R9 gmask off");
        wr(A_CTL, 16'hBF05);
        check({15'd0, irq_n}, 16'h0000, "R9 gmask back on");
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(A_CTL, 16'hBB05);             // drop enable 2
        rd(A_STS, v); check(v, 16'h0001, "R6 cleared by enable 0");
        wr(A_CTL, 16'hBF05);
        rd(A_STS, v); check(v, 16'h0001, "R6 re-armed stays clear");
        wr(A_CTL, 16'hBE05);             // drop enable 0
        check({15'd0, irq_n}, 16'h0001, "R10 level releases");
        wr(A_CTL, 16'hBF05);
    endtask

    task automatic t_race;
        logic [15:0] v;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_CTL; bus_wdata = 16'hB705;
        src_in = 6'h08;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; src_in = '0;
        rd(A_STS, v); check(v, 16'h0000, "R7 same-cycle event dropped");
        wr(A_CTL, 16'hBF05);
        rd(A_STS, v); check(v, 16'h0000, "R7 stays clear after re-arm");
    endtask

    task automatic count_lows(output int lows);
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            if (!irq_n) lows++;
            @(negedge clk);
        end
    endtask

    task automatic t_pulse;
        int lows;
        wr(A_CTL, 16'hFF3F);             // gmask, pulse mode, all on
        check({15'd0, irq_n}, 16'h0001, "R11 idle high");
        @(negedge clk); src_in = 6'h10;
        @(negedge clk); src_in = '0;
        check({15'd0, irq_n}, 16'h0000, "R11 pulse starts at latch edge");
        count_lows(lows);
        check(16'(lows), 16'd4, "R11 pulse width");
        pulse(6'h10);
        count_lows(lows);
        check(16'(lows), 16'd0, "R11 no pulse for set bit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        t_latch_mask();
        t_clear();
        t_race();
        t_pulse();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule